// File: doc/BRIEF.md
# Link capability and status derivation

This block computes the link-capability and link-status fields of a PCIe-style downstream port. Two configuration inputs give the port's largest lane width and fastest speed. From them the block drives a set of capability fields at once, with no register in the path: the sanitized maximums, a bandwidth-notification flag, a data-link-active reporting flag, a link-active status bit, a target-speed control value and a supported-speeds vector.

A separate sync strobe takes a snapshot of the attached device's reported width and speed, together with a flag that says whether a device is present. It stores a negotiated width and speed that never exceed the port's own limits. A minimal read port returns any of four 32-bit words, one cycle after the request.

Speed codes are 1 = 2.5 GT/s, 2 = 5 GT/s, 3 = 8 GT/s and 4 = 16 GT/s. Width codes are lane counts, and 1 is x1.

Top module: `lnk_status_ctrl`

## Requirements
- R1: A configured speed outside 1..4 is treated as speed 1. A configured width other than 1, 2, 4, 8, 16 or 32 is treated as width 1. The sanitized values appear on `cap_max_speed` and `cap_max_width`.
- R2: `cap_bw_notify` is 1 exactly when the sanitized width is above 1 or the sanitized speed is above 1.
- R3: When the sanitized speed is above 1, `cap_dll_rpt` and `lnk_active` are both 1. Otherwise both are 0.
- R4: `tgt_speed` equals the sanitized speed when that speed is above 1. Otherwise it is 0.
- R5: `sup_speeds` bit k (bit 0 = 2.5, bit 1 = 5, bit 2 = 8, bit 3 = 16 GT/s) is set when the sanitized speed is above 2 and k is below that speed. When the sanitized speed is 1 or 2, all bits are 0.
- R6: Reset is synchronous and active high. It sets the negotiated width to 1, the negotiated speed to 1 and `rd_data` to 0.
- R7: On a sync with `ds_present` low, the negotiated width and speed take the sanitized maximums.
- R8: On a sync with a device present, a reported width above the maximum becomes the maximum. A reported width of zero, or any other unsupported width, becomes 1. A supported width is kept.
- R9: On a sync with a device present, a reported speed above the maximum becomes the maximum, and a reported speed of zero becomes 1. Any other speed is kept.
- R10: The negotiated values change only in the cycle after a sync strobe. At all other times they hold, even when the device inputs change.
- R11: When `rd_en` is high, the selected word appears on `rd_data` one cycle later. The words are:
  - address 0: [3:0] max speed, [9:4] max width, [10] bandwidth notify, [11] link-active reporting;
  - address 1: [3:0] negotiated speed, [9:4] negotiated width, [10] link active;
  - address 2: [3:0] target speed;
  - address 3: [3:0] supported-speeds vector.
  
  All other bits read 0. While `rd_en` is low, `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_width | input | 6 | Configured maximum width code |
| cfg_speed | input | 4 | Configured maximum speed code |
| ds_present | input | 1 | Attached device is present |
| ds_width | input | 6 | Width reported by the attached device |
| ds_speed | input | 4 | Speed reported by the attached device |
| sync | input | 1 | Capture strobe for the negotiated status |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read word select |
| cap_max_width | output | 6 | Sanitized maximum width |
| cap_max_speed | output | 4 | Sanitized maximum speed |
| cap_bw_notify | output | 1 | Bandwidth-notification capability |
| cap_dll_rpt | output | 1 | Data-link-active reporting capability |
| lnk_active | output | 1 | Link-active status bit |
| tgt_speed | output | 4 | Target link speed control value |
| sup_speeds | output | 4 | Supported-speeds vector |
| neg_width | output | 6 | Registered negotiated width |
| neg_speed | output | 4 | Registered negotiated speed |
| rd_data | output | 32 | Registered read data |

## Verification
Assertions run on every cycle and cover these rules:
- the negotiated pair holds between strobes;
- after a strobe it never exceeds the maximums captured with it, and it copies them when no device is present;
- it returns to x1 at 2.5 GT/s out of reset;
- the target speed, when nonzero, agrees with the maximum;
- read data holds while no read is requested.

Only the bench scenarios can show the actual values. These include the cases where zero or unsupported reported values become minimums, where invalid configured codes fall back to the minimum, the threshold patterns of the supported-speeds vector, and the bit layout of each read word.

// File: rtl/lnk_pkg.sv
`timescale 1ns/1ps
package lnk_pkg;
  parameter int SPD_W   = 4;
  parameter int WID_W   = 6;
  parameter int SPD_MIN = 1;
  parameter int WID_MIN = 1;

  typedef struct packed {
    logic [WID_W-1:0] wid;
    logic [SPD_W-1:0] spd;
  } lnk_pair_t;

  // power of two, nonzero, no wider than the limit
  function automatic logic wid_supported(input logic [WID_W-1:0] w, input int max_w);
    return (w != '0) && ((w & (w - 1'b1)) == '0) && (int'(w) <= max_w);
  endfunction

  function automatic logic spd_supported(input logic [SPD_W-1:0] s, input int max_s);
    return (s != '0) && (int'(s) <= max_s);
  endfunction
endpackage

// File: rtl/lnk_cap_derive.sv
`timescale 1ns/1ps
module lnk_cap_derive
  import lnk_pkg::*;
#(
  parameter int MAX_SPEED = 4,
  parameter int MAX_WIDTH = 32
) (
  input  logic [WID_W-1:0]     cfg_width,
  input  logic [SPD_W-1:0]     cfg_speed,
  output lnk_pair_t            max_pair,
  output logic                 bw_notify,
  output logic                 dll_rpt,
  output logic                 link_up,
  output logic [SPD_W-1:0]     tgt_speed,
  output logic [MAX_SPEED-1:0] sup_vec
);
  localparam logic [SPD_W-1:0] SPD_LO = SPD_W'(SPD_MIN);
  localparam logic [WID_W-1:0] WID_LO = WID_W'(WID_MIN);

  logic above_base;

  always_comb begin
    max_pair.wid = wid_supported(cfg_width, MAX_WIDTH) ? cfg_width : WID_LO;
    max_pair.spd = spd_supported(cfg_speed, MAX_SPEED) ? cfg_speed : SPD_LO;
    above_base   = (max_pair.spd > SPD_LO);
    bw_notify    = above_base || (max_pair.wid > WID_LO);
    dll_rpt      = above_base;
    link_up      = above_base;
    tgt_speed    = above_base ? max_pair.spd : '0;
  end

  // one flag per speed; listed only when the speed is past 5 GT/s
  for (genvar k = 0; k < MAX_SPEED; k++) begin : g_sup
    assign sup_vec[k] = (int'(max_pair.spd) > 2) && (int'(max_pair.spd) > k);
  end
endmodule

// File: rtl/lnk_sync_clamp.sv
`timescale 1ns/1ps
module lnk_sync_clamp
  import lnk_pkg::*;
#(
  parameter int MAX_WIDTH = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      sync,
  input  logic      ds_present,
  input  lnk_pair_t ds_pair,
  input  lnk_pair_t max_pair,
  output lnk_pair_t neg_pair
);
  localparam logic [SPD_W-1:0] SPD_LO = SPD_W'(SPD_MIN);
  localparam logic [WID_W-1:0] WID_LO = WID_W'(WID_MIN);

  lnk_pair_t nxt;

  always_comb begin
    if (!ds_present) begin
      nxt = max_pair;
    end else begin
      if (ds_pair.wid > max_pair.wid)                nxt.wid = max_pair.wid;
      else if (!wid_supported(ds_pair.wid, MAX_WIDTH)) nxt.wid = WID_LO;
      else                                           nxt.wid = ds_pair.wid;
      if (ds_pair.spd > max_pair.spd)  nxt.spd = max_pair.spd;
      else if (ds_pair.spd == '0)      nxt.spd = SPD_LO;
      else                             nxt.spd = ds_pair.spd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      neg_pair.wid <= WID_LO;
      neg_pair.spd <= SPD_LO;
    end else if (sync) begin
      neg_pair <= nxt;
    end
  end

  assert_reset_val_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (neg_pair.wid == WID_LO && neg_pair.spd == SPD_LO));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sync)) |-> $stable(neg_pair));
  assert_absent_copy_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sync) && !$past(ds_present)) |-> (neg_pair == $past(max_pair)));
  assert_wid_clamp_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sync)) |-> (neg_pair.wid <= $past(max_pair.wid) && neg_pair.wid != '0));
  assert_spd_clamp_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sync)) |-> (neg_pair.spd <= $past(max_pair.spd) && neg_pair.spd != '0));
endmodule

// File: rtl/lnk_reg_read.sv
`timescale 1ns/1ps
module lnk_reg_read
  import lnk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int MAX_SPEED = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  lnk_pair_t            max_pair,
  input  lnk_pair_t            neg_pair,
  input  logic                 bw_notify,
  input  logic                 dll_rpt,
  input  logic                 link_up,
  input  logic [SPD_W-1:0]     tgt_speed,
  input  logic [MAX_SPEED-1:0] sup_vec,
  output logic [DATA_W-1:0]    rd_data
);
  logic [DATA_W-1:0] word_sel;

  always_comb begin
    case (rd_addr)
      ADDR_W'(0): word_sel = DATA_W'({dll_rpt, bw_notify, max_pair.wid, max_pair.spd});
      ADDR_W'(1): word_sel = DATA_W'({link_up, neg_pair.wid, neg_pair.spd});
      ADDR_W'(2): word_sel = DATA_W'(tgt_speed);
      ADDR_W'(3): word_sel = DATA_W'(sup_vec);
      default:    word_sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= word_sel;
  end

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rd_en)) |-> $stable(rd_data));
  assert_rd_neg_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(rd_addr) == ADDR_W'(1))
      |-> (rd_data[SPD_W+WID_W-1:0] == $past(neg_pair)));
endmodule

// File: rtl/lnk_status_ctrl.sv
`timescale 1ns/1ps
module lnk_status_ctrl
  import lnk_pkg::*;
#(
  parameter int MAX_SPEED = 4,
  parameter int MAX_WIDTH = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WID_W-1:0]     cfg_width,
  input  logic [SPD_W-1:0]     cfg_speed,
  input  logic                 ds_present,
  input  logic [WID_W-1:0]     ds_width,
  input  logic [SPD_W-1:0]     ds_speed,
  input  logic                 sync,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [WID_W-1:0]     cap_max_width,
  output logic [SPD_W-1:0]     cap_max_speed,
  output logic                 cap_bw_notify,
  output logic                 cap_dll_rpt,
  output logic                 lnk_active,
  output logic [SPD_W-1:0]     tgt_speed,
  output logic [MAX_SPEED-1:0] sup_speeds,
  output logic [WID_W-1:0]     neg_width,
  output logic [SPD_W-1:0]     neg_speed,
  output logic [DATA_W-1:0]    rd_data
);
  lnk_pair_t max_pair, neg_pair, ds_pair;

  assign ds_pair.wid = ds_width;
  assign ds_pair.spd = ds_speed;

  lnk_cap_derive #(.MAX_SPEED(MAX_SPEED), .MAX_WIDTH(MAX_WIDTH)) cap_i (
    .cfg_width (cfg_width),
    .cfg_speed (cfg_speed),
    .max_pair  (max_pair),
    .bw_notify (cap_bw_notify),
    .dll_rpt   (cap_dll_rpt),
    .link_up   (lnk_active),
    .tgt_speed (tgt_speed),
    .sup_vec   (sup_speeds)
  );

  lnk_sync_clamp #(.MAX_WIDTH(MAX_WIDTH)) clamp_i (
    .clk        (clk),
    .rst        (rst),
    .sync       (sync),
    .ds_present (ds_present),
    .ds_pair    (ds_pair),
    .max_pair   (max_pair),
    .neg_pair   (neg_pair)
  );

  lnk_reg_read #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_SPEED(MAX_SPEED)) rd_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .max_pair  (max_pair),
    .neg_pair  (neg_pair),
    .bw_notify (cap_bw_notify),
    .dll_rpt   (cap_dll_rpt),
    .link_up   (lnk_active),
    .tgt_speed (tgt_speed),
    .sup_vec   (sup_speeds),
    .rd_data   (rd_data)
  );

  assign cap_max_width = max_pair.wid;
  assign cap_max_speed = max_pair.spd;
  assign neg_width     = neg_pair.wid;
  assign neg_speed     = neg_pair.spd;

  assert_tgt_match_R4: assert property (@(posedge clk) disable iff (rst)
    (tgt_speed != '0) |-> (tgt_speed == cap_max_speed && lnk_active));
  assert_notify_R2: assert property (@(posedge clk) disable iff (rst)
    (cap_max_width > WID_W'(WID_MIN)) |-> cap_bw_notify);
endmodule

// File: tb/lnk_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module lnk_status_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_width = '0;
  logic [3:0]  cfg_speed = '0;
  logic        ds_present = 1'b0;
  logic [5:0]  ds_width = '0;
  logic [3:0]  ds_speed = '0;
  logic        sync = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [5:0]  cap_max_width;
  logic [3:0]  cap_max_speed;
  logic        cap_bw_notify, cap_dll_rpt, lnk_active;
  logic [3:0]  tgt_speed, sup_speeds;
  logic [5:0]  neg_width;
  logic [3:0]  neg_speed;
  logic [31:0] rd_data;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  always #5 clk = ~clk;

  lnk_status_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_speed(cfg_speed),
    .ds_present(ds_present), .ds_width(ds_width), .ds_speed(ds_speed),
    .sync(sync), .rd_en(rd_en), .rd_addr(rd_addr),
    .cap_max_width(cap_max_width), .cap_max_speed(cap_max_speed),
    .cap_bw_notify(cap_bw_notify), .cap_dll_rpt(cap_dll_rpt),
    .lnk_active(lnk_active), .tgt_speed(tgt_speed), .sup_speeds(sup_speeds),
    .neg_width(neg_width), .neg_speed(neg_speed), .rd_data(rd_data)
  );

  // {cfg_w, cfg_s, present, ds_w, ds_s, exp_w, exp_s}
  localparam logic [30:0] VEC [12] = '{
    {6'd1,  4'd1, 1'b0, 6'd0,  4'd0,  6'd1,  4'd1},
    {6'd16, 4'd3, 1'b0, 6'd4,  4'd2,  6'd16, 4'd3},
    {6'd8,  4'd2, 1'b1, 6'd4,  4'd1,  6'd4,  4'd1},
    {6'd8,  4'd2, 1'b1, 6'd16, 4'd3,  6'd8,  4'd2},
    {6'd4,  4'd4, 1'b1, 6'd0,  4'd0,  6'd1,  4'd1},
    {6'd32, 4'd4, 1'b1, 6'd32, 4'd4,  6'd32, 4'd4},
    {6'd3,  4'd7, 1'b0, 6'd0,  4'd0,  6'd1,  4'd1},
    {6'd16, 4'd3, 1'b1, 6'd3,  4'd2,  6'd1,  4'd2},
    {6'd2,  4'd1, 1'b1, 6'd63, 4'd15, 6'd2,  4'd1},
    {6'd0,  4'd0, 1'b1, 6'd1,  4'd1,  6'd1,  4'd1},
    {6'd12, 4'd4, 1'b1, 6'd8,  4'd9,  6'd1,  4'd4},
    {6'd32, 4'd2, 1'b1, 6'd16, 4'd2,  6'd16, 4'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model written from the requirement text
  function automatic logic [31:0] model(input int a, input logic [5:0] cw, input logic [3:0] cs,
                                        input logic [5:0] nw, input logic [3:0] ns);
    int w, s;
    w = (cw inside {6'd1, 6'd2, 6'd4, 6'd8, 6'd16, 6'd32}) ? int'(cw) : 1;
    s = (cs >= 4'd1 && cs <= 4'd4) ? int'(cs) : 1;
    case (a)
      0:       model = {20'd0, (s > 1), (w > 1 || s > 1), 6'(w), 4'(s)};
      1:       model = {21'd0, (s > 1), nw, ns};
      2:       model = (s > 1) ? 32'(s) : 32'd0;
      default: model = (s > 2) ? 32'((1 << s) - 1) : 32'd0;
    endcase
  endfunction

  task automatic rd_word(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic apply(input logic [5:0] cw, input logic [3:0] cs, input logic p,
                       input logic [5:0] dw, input logic [3:0] ds);
    @(negedge clk);
    cfg_width = cw; cfg_speed = cs; ds_present = p; ds_width = dw; ds_speed = ds; sync = 1'b1;
    @(negedge clk); sync = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, held;
    logic [5:0] pw;
    logic [3:0] ps;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R6 reset state
    chk("R6 neg width after reset", 32'(neg_width), 32'd1);
    chk("R6 neg speed after reset", 32'(neg_speed), 32'd1);
    chk("R6 rd_data after reset", rd_data, 32'd0);
    // R1 zero config falls back to minimum
    chk("R1 cap width for code 0", 32'(cap_max_width), 32'd1);
    chk("R1 cap speed for code 0", 32'(cap_max_speed), 32'd1);

    for (int i = 0; i < 12; i++) begin
      logic [30:0] v;
      v = VEC[i];
      apply(v[30:25], v[24:21], v[20], v[19:14], v[13:10]);
      chk($sformatf("R7/R8 vec %0d neg width", i), 32'(neg_width), 32'(v[9:4]));
      chk($sformatf("R7/R9 vec %0d neg speed", i), 32'(neg_speed), 32'(v[3:0]));
      for (int a = 0; a < 4; a++) begin
        rd_word(2'(a), d);
        chk($sformatf("R1/R2/R3/R4/R5/R11 vec %0d word %0d", i, a), d,
            model(a, v[30:25], v[24:21], v[9:4], v[3:0]));
      end
    end

    // R2 width alone raises bandwidth notify; R3 stays low at speed 1
    @(negedge clk); cfg_width = 6'd2; cfg_speed = 4'd1; #1;
    chk("R2 notify for width 2 speed 1", 32'(cap_bw_notify), 32'd1);
    chk("R3 link-active reporting at speed 1", 32'({cap_dll_rpt, lnk_active}), 32'd0);
    chk("R4 target speed at speed 1", 32'(tgt_speed), 32'd0);
    // R5 speed 2 gives an empty vector, speed 3 gives three bits
    cfg_speed = 4'd2; #1;
    chk("R5 vector at speed 2", 32'(sup_speeds), 32'd0);
    cfg_speed = 4'd3; #1;
    chk("R5 vector at speed 3", 32'(sup_speeds), 32'h7);
    chk("R3 link active at speed 3", 32'({cap_dll_rpt, lnk_active}), 32'd3);

    // R10: no change before the strobe edge, nor without a strobe
    apply(6'd8, 4'd3, 1'b1, 6'd8, 4'd3);
    pw = neg_width; ps = neg_speed;
    @(negedge clk); ds_width = 6'd2; ds_speed = 4'd1; sync = 1'b1; #1;
    chk("R10 width unchanged before strobe edge", 32'(neg_width), 32'(pw));
    sync = 1'b0; ds_present = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 width held without strobe", 32'(neg_width), 32'(pw));
    chk("R10 speed held without strobe", 32'(neg_speed), 32'(ps));

    // R11: rd_data holds while rd_en is low
    rd_word(2'd0, held);
    @(negedge clk); rd_addr = 2'd3; cfg_speed = 4'd4; cfg_width = 6'd16;
    repeat (2) @(negedge clk);
    chk("R11 rd_data held with rd_en low", rd_data, held);

    // R9 speed zero with device present becomes 1 while width is kept
    apply(6'd16, 4'd4, 1'b1, 6'd16, 4'd0);
    chk("R9 zero speed becomes 1", 32'(neg_speed), 32'd1);
    chk("R8 supported width kept", 32'(neg_width), 32'd16);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule